// File: doc/BRIEF.md
# HDLC Receive Bit Processor

This block sits behind a serial receiver and turns a raw HDLC bit stream into bytes. A bit is taken only on a cycle where the bit-rate strobe and the receive enable are both high. Each accepted bit does four things. It updates a count of consecutive ones, which lets the block delete stuff zeros. It enters a sliding window that is compared against a programmable pattern under a mask; the intended pattern is the 0x7E flag. After an eight-step delay it feeds a bit-serial CRC-16 and a byte packer.

A window match marks a flag. The flag bits in the window are dropped, the CRC restarts from its preset and byte alignment restarts. A closing flag whose preceding data leaves the expected residue in the CRC raises a frame-good pulse. A run of seven ones is an abort: the partial byte is thrown away and output stays silent until the next flag. The running CRC is visible on a port at all times.

Top module: `hdlc_rx_bitproc`

## Requirements
- R1: A 0 bit that arrives after exactly five consecutive 1 bits is deleted. It never appears in an output byte and never enters the CRC.
- R2: The window holds the last eight accepted raw bits, with bit 0 the newest and bit 7 the oldest. A flag is recognised when `((window ^ flag_cmp) & ~flag_mask) == 0`; a mask bit of 1 excludes that position from the comparison. `flag_det` pulses for one cycle on the cycle after the step that completed the match.
- R3: A flag restarts the CRC at 0xFFFF and restarts byte alignment; `crc_value` reads 0xFFFF while `flag_det` is high. The eight bits that formed the flag never reach the output bytes or the CRC.
- R4: For each data bit d, the CRC register c becomes `{c[14:0],0}`, XORed with 0x1021 when `c[15]^d` is 1. The register is preset to 0xFFFF.
- R5: Data bits are packed eight to a byte, with the earliest bit in bit 0. `byte_valid` pulses for one cycle after the step that emits the eighth bit, and `crc_value` at that moment includes that bit.
- R6: A bit is processed only when `rx_en` and `bit_en` are both 1. On any other cycle no output and no internal state changes.
- R7: When a seventh consecutive 1 is accepted, `abort_det` pulses once and the partial byte is discarded. An abort takes precedence over a mask match on that same step.
- R8: `frame_good` pulses together with a closing `flag_det` when three conditions hold: a frame was open, at least one whole byte arrived since the opening flag and no partial byte is pending, and the CRC after the last data bit equals 0x1D0F. This is the residue left when the sender appends the complemented CRC, bit 15 first.
- R9: Before the first flag, and after an abort until the next flag, no bytes are produced.
- R10: After reset `crc_value` is 0xFFFF and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| bit_en | input | 1 | One-cycle strobe marking a valid `bit_in` |
| bit_in | input | 1 | Serial receive bit |
| flag_cmp | input | 8 | Flag compare pattern (normally 0x7E) |
| flag_mask | input | 8 | Compare mask, 1 = position ignored (normally 0x01) |
| byte_data | output | 8 | Received byte, earliest bit in bit 0 |
| byte_valid | output | 1 | One-cycle pulse qualifying `byte_data` |
| crc_value | output | 16 | Running CRC register |
| flag_det | output | 1 | One-cycle pulse on flag recognition |
| abort_det | output | 1 | One-cycle pulse on a run of seven ones |
| frame_good | output | 1 | One-cycle pulse on a closing flag with a good CRC |

## Verification
The assertions assume that `flag_cmp` and `flag_mask` change only while no bit strobe is being accepted. They also assume that the default pattern and mask are used whenever the mutual exclusion of abort and flag is relied on. The stimulus changes the compare pair only during idle gaps and restores the default before any framed traffic. The property that two byte pulses are never adjacent depends on every byte needing eight accepted bits. The bench only issues strobes as single-cycle pulses with zero to two idle cycles between them, which keeps within that assumption.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned WIN_W     = 8;
    parameter int unsigned CRC_W     = 16;
    parameter int unsigned RUN_STUFF = 5;
    parameter int unsigned RUN_ABORT = 7;

    parameter logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
    parameter logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
    parameter logic [CRC_W-1:0] CRC_GOOD   = 16'h1D0F;

    localparam int unsigned RUN_CW = $clog2(RUN_ABORT + 1);
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    // one position of the delay window
    typedef struct packed {
        logic vld;   // bit belongs to the current frame body
        logic keep;  // bit is data, not a deleted stuff zero
        logic dat;   // raw bit value
    } slot_t;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    function automatic logic [CRC_W-1:0] crc_shift(
        input logic [CRC_W-1:0] c,
        input logic             d
    );
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    endfunction

endpackage

// File: rtl/hdlc_rx_front.sv
module hdlc_rx_front
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             din,
    input  logic [WIN_W-1:0] cmp,
    input  logic [WIN_W-1:0] mask,
    output logic             emit_ok,
    output logic             emit_bit,
    output logic             flag_hit,
    output logic             abort_hit
);

    slot_t [WIN_W-1:0] win_q;
    logic [RUN_CW-1:0] run_q;
    logic [WIN_W-1:0]  raw_nxt;
    logic              match;
    logic              stuff;
    logic              drop;

    // raw view of the window after this step's shift
    assign raw_nxt[0] = din;
    for (genvar g = 1; g < WIN_W; g++) begin : g_raw
        assign raw_nxt[g] = win_q[g-1].dat;
    end

    assign match     = ((raw_nxt ^ cmp) & ~mask) == '0;
    assign abort_hit = step & din & (run_q == RUN_CW'(RUN_ABORT - 1));
    assign flag_hit  = step & match & ~abort_hit;
    assign stuff     = ~din & (run_q == RUN_CW'(RUN_STUFF));
    assign drop      = flag_hit | abort_hit;

    assign emit_ok  = step & win_q[WIN_W-1].vld & win_q[WIN_W-1].keep;
    assign emit_bit = win_q[WIN_W-1].dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            win_q <= '0;
        end else if (step) begin
            if (!din) begin
                run_q <= '0;
            end else if (run_q != RUN_CW'(RUN_ABORT)) begin
                run_q <= run_q + 1'b1;
            end
            for (int i = WIN_W - 1; i > 0; i--) begin
                win_q[i].dat  <= win_q[i-1].dat;
                win_q[i].keep <= win_q[i-1].keep;
                win_q[i].vld  <= win_q[i-1].vld & ~drop;
            end
            win_q[0].dat  <= din;
            win_q[0].keep <= ~stuff;
            win_q[0].vld  <= ~drop;
        end
    end

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(run_q));

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_upd
);

    assign crc_upd = step ? crc_shift(crc_q, din) : crc_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            crc_q <= CRC_PRESET;
        end else begin
            crc_q <= crc_upd;
        end
    end

    // R6
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(step || restart) |=> $stable(crc_q));

endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              din,
    input  logic              clear,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_vld,
    output logic              aligned_upd,
    output logic              has_upd
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_upd;
    logic [BYTE_W-1:0] sh_q;
    logic              has_q;
    logic              last;

    assign last        = push & (cnt_q == CNT_W'(BYTE_W - 1));
    assign cnt_upd     = !push ? cnt_q : (last ? '0 : cnt_q + 1'b1);
    assign aligned_upd = cnt_upd == '0;
    assign has_upd     = has_q | last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            has_q    <= 1'b0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= last;
            if (last) begin
                byte_q <= {din, sh_q[BYTE_W-1:1]};
            end
            if (push) begin
                sh_q <= {din, sh_q[BYTE_W-1:1]};
            end
            cnt_q <= clear ? '0 : cnt_upd;
            has_q <= clear ? 1'b0 : has_upd;
        end
    end

    // R5
    byte_gap_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

endmodule

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [WIN_W-1:0]  flag_cmp,
    input  logic [WIN_W-1:0]  flag_mask,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic [CRC_W-1:0]  crc_value,
    output logic              flag_det,
    output logic              abort_det,
    output logic              frame_good
);

    rx_state_e        state_q;
    logic             step;
    logic             emit_ok;
    logic             emit_bit;
    logic             flag_hit;
    logic             abort_hit;
    logic             push;
    logic [CRC_W-1:0] crc_upd;
    logic             aligned_upd;
    logic             has_upd;
    logic             in_frame;

    assign step     = rx_en & bit_en;
    assign in_frame = state_q == ST_FRAME;
    assign push     = emit_ok & in_frame & ~abort_hit;

    hdlc_rx_front u_front (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .din       (bit_in),
        .cmp       (flag_cmp),
        .mask      (flag_mask),
        .emit_ok   (emit_ok),
        .emit_bit  (emit_bit),
        .flag_hit  (flag_hit),
        .abort_hit (abort_hit)
    );

    hdlc_rx_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .step    (push),
        .restart (flag_hit),
        .din     (emit_bit),
        .crc_q   (crc_value),
        .crc_upd (crc_upd)
    );

    hdlc_rx_packer u_pack (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .din         (emit_bit),
        .clear       (flag_hit | abort_hit),
        .byte_q      (byte_data),
        .byte_vld    (byte_valid),
        .aligned_upd (aligned_upd),
        .has_upd     (has_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HUNT;
            flag_det   <= 1'b0;
            abort_det  <= 1'b0;
            frame_good <= 1'b0;
        end else begin
            if (abort_hit) begin
                state_q <= ST_HUNT;
            end else if (flag_hit) begin
                state_q <= ST_FRAME;
            end
            flag_det   <= flag_hit;
            abort_det  <= abort_hit;
            frame_good <= flag_hit & in_frame & aligned_upd & has_upd
                          & (crc_upd == CRC_GOOD);
        end
    end

    // R3
    flag_preset_chk: assert property (@(posedge clk) disable iff (rst)
        flag_det |-> crc_value == CRC_PRESET);

    // R7
    abort_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        abort_det |-> !flag_det);

    // R8
    good_on_flag_chk: assert property (@(posedge clk) disable iff (rst)
        frame_good |-> flag_det);

    // R9
    hunt_silent_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(in_frame));

endmodule

// File: tb/tb_hdlc_rx_bitproc.sv
module tb_hdlc_rx_bitproc;

    localparam int CLK_NS     = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  flag_cmp = 8'h7E;
    logic [7:0]  flag_mask = 8'h01;
    logic [7:0]  byte_data;
    logic        byte_valid;
    logic [15:0] crc_value;
    logic        flag_det;
    logic        abort_det;
    logic        frame_good;

    always #(CLK_NS / 2) clk = ~clk;

    hdlc_rx_bitproc dut (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .flag_cmp   (flag_cmp),
        .flag_mask  (flag_mask),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .crc_value  (crc_value),
        .flag_det   (flag_det),
        .abort_det  (abort_det),
        .frame_good (frame_good)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor
    int         got_n = 0, flag_n = 0, abort_n = 0, good_n = 0;
    logic [7:0]  got_b [32];
    logic [15:0] got_c [32];

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (got_n < 32) begin
                    got_b[got_n] = byte_data;
                    got_c[got_n] = crc_value;
                end
                got_n++;
            end
            if (flag_det) begin
                flag_n++;
                chk(crc_value == 16'hFFFF, "R3 crc preset at flag", crc_value, 16'hFFFF);
            end
            if (abort_det) abort_n++;
            if (frame_good) good_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_CYCLES) begin
            n_fail++;
            $display("FAIL watchdog R1-all: actual %0d expected below %0d", cyc, WD_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // transmitter model
    int tx_ones = 0;
    int gap = 0;
    logic [7:0]  pl    [8];
    logic [7:0]  exp_b [32];
    logic [15:0] exp_c [32];
    int exp_n = 0;

    task automatic put_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic data_bit(input logic b);
        put_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                put_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic put_flag();
        put_bit(1'b0);
        for (int k = 0; k < 6; k++) put_bit(1'b1);
        put_bit(1'b0);
        tx_ones = 0;
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic d);
        logic [15:0] r;
        r = c << 1;
        if (c[15] != d) r = r ^ 16'h1021;
        return r;
    endfunction

    task automatic send_frame(input int n, input bit corrupt);
        logic [15:0] c;
        logic [15:0] fcs;
        logic [7:0]  fb;
        c = 16'hFFFF;
        fb = 8'h00;
        exp_n = 0;
        put_flag();
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                data_bit(pl[i][k]);
                c = crc_bit(c, pl[i][k]);
            end
            exp_b[exp_n] = pl[i];
            exp_c[exp_n] = c;
            exp_n++;
        end
        fcs = ~c;
        if (corrupt) fcs[0] = ~fcs[0];
        for (int k = 0; k < 16; k++) begin
            data_bit(fcs[15-k]);
            fb[k % 8] = fcs[15-k];
            if (k % 8 == 7) begin
                exp_b[exp_n] = fb;
                exp_c[exp_n] = 16'hFFFF;
                exp_n++;
            end
        end
        put_flag();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mon();
        got_n = 0;
        flag_n = 0;
        abort_n = 0;
        good_n = 0;
    endtask

    task automatic check_bytes(input string tag, input int n_pay);
        chk(got_n == exp_n, {tag, " byte count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_b[i] == exp_b[i], {tag, " byte value"}, got_b[i], exp_b[i]);
            if (i < n_pay)
                chk(got_c[i] == exp_c[i], "R4 running crc", got_c[i], exp_c[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(crc_value == 16'hFFFF, "R10 crc reset", crc_value, 16'hFFFF);
        chk(byte_valid == 1'b0, "R10 byte_valid reset", byte_valid, 0);
        chk(flag_det == 1'b0, "R10 flag_det reset", flag_det, 0);
        chk(abort_det == 1'b0, "R10 abort_det reset", abort_det, 0);
        chk(frame_good == 1'b0, "R10 frame_good reset", frame_good, 0);

        // R9 data before any flag is ignored
        clear_mon();
        for (int k = 0; k < 8; k++) data_bit(8'h99 >> k);
        for (int k = 0; k < 8; k++) data_bit(8'hF3 >> k);
        repeat (3) @(negedge clk);
        chk(got_n == 0, "R9 no bytes while hunting", got_n, 0);
        chk(flag_n == 0, "R9 no flag while hunting", flag_n, 0);

        // R1 R4 R5 R6 R8 sweep of every single-byte payload with strobe gaps
        for (int v = 0; v < 256; v++) begin
            gap = v % 3;
            clear_mon();
            pl[0] = 8'(v);
            send_frame(1, 1'b0);
            check_bytes("R1 R5 R6 sweep", 1);
            chk(good_n == 1, "R8 good frame", good_n, 1);
            chk(flag_n == 2, "R2 flags per frame", flag_n, 2);
        end
        gap = 0;

        // R8 multi-byte frame with flag-like and stuffed data, good then bad FCS
        pl[0] = 8'h7E; pl[1] = 8'hFF; pl[2] = 8'hFF; pl[3] = 8'h00;
        pl[4] = 8'h7D; pl[5] = 8'h1F; pl[6] = 8'hF8;
        clear_mon();
        send_frame(7, 1'b0);
        check_bytes("R1 R5 multi", 7);
        chk(good_n == 1, "R8 multi good", good_n, 1);
        clear_mon();
        send_frame(7, 1'b1);
        check_bytes("R5 corrupt", 7);
        chk(good_n == 0, "R8 corrupt fcs rejected", good_n, 0);

        // R7 abort: partial byte discarded, silence until next flag
        clear_mon();
        put_flag();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        for (int k = 0; k < 7; k++) put_bit(1'b1);
        repeat (2) @(negedge clk);
        chk(abort_n == 1, "R7 abort pulse", abort_n, 1);
        chk(flag_n == 1, "R7 abort beats mask match", flag_n, 1);
        chk(got_n == 0, "R7 partial byte dropped", got_n, 0);
        tx_ones = 0;
        for (int k = 0; k < 8; k++) data_bit(8'h55 >> k);
        for (int k = 0; k < 8; k++) data_bit(8'hC6 >> k);
        repeat (2) @(negedge clk);
        chk(got_n == 0, "R9 silent after abort", got_n, 0);
        chk(abort_n == 1, "R7 single abort pulse", abort_n, 1);
        pl[0] = 8'hA5; pl[1] = 8'h3C;
        send_frame(2, 1'b0);
        check_bytes("R3 R5 after abort", 2);
        chk(good_n == 1, "R8 good after abort", good_n, 1);
        chk(flag_n == 3, "R2 flags after abort", flag_n, 3);

        // R2 programmable compare and mask
        flag_cmp = 8'hA5;
        flag_mask = 8'h0F;
        clear_mon();
        for (int k = 0; k < 8; k++) put_bit(1'b0);
        repeat (2) @(negedge clk);
        chk(flag_n == 0, "R2 no match on zeros", flag_n, 0);
        for (int k = 0; k < 8; k++) put_bit(k % 2 == 0);
        repeat (2) @(negedge clk);
        chk(flag_n == 1, "R2 masked pattern match", flag_n, 1);
        flag_cmp = 8'h7E;
        flag_mask = 8'h01;

        // R6 receive disabled: nothing moves
        begin
            logic [15:0] crc_before;
            pl[0] = 8'h42;
            send_frame(1, 1'b0);
            crc_before = crc_value;
            rx_en = 1'b0;
            clear_mon();
            pl[0] = 8'h81; pl[1] = 8'h18;
            send_frame(2, 1'b0);
            chk(flag_n == 0, "R6 no flag when disabled", flag_n, 0);
            chk(got_n == 0, "R6 no bytes when disabled", got_n, 0);
            chk(crc_value == crc_before, "R6 crc held when disabled", crc_value, crc_before);
            rx_en = 1'b1;
            clear_mon();
            send_frame(2, 1'b0);
            check_bytes("R6 re-enabled", 2);
            chk(good_n == 1, "R8 good after re-enable", good_n, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule